// File: doc/BRIEF.md
# Request-to-Acknowledge Strobe Count Monitor

This block watches a three-wire handshake on one clock: a request that opens a transaction, an interim valid strobe that marks partial progress, and an acknowledge that ends the transaction. The monitor counts valid events inside each window. When the acknowledge arrives it compares the count with a minimum that is set by a parameter, and it reports a one-cycle pass or fail verdict.

The valid events do not have to be back to back. Any number of quiet cycles may separate them, and the number of events may change from one transaction to the next. A parameter chooses what counts as an event. In rise mode only the low-to-high change of the valid strobe counts. In both-edges mode every change of its level counts.

The monitor also reports misuse of the handshake as one-cycle strobes:
- an acknowledge that coincides with an active valid;
- an acknowledge that arrives with no transaction open;
- a request that restarts a transaction which is already open.

Two saturating counters keep the totals of pass and fail verdicts. It is meant to sit beside a design as a synthesizable protocol watchdog.

Top module: `hs_window_monitor`

## Requirements
- R1: While reset is asserted, and after reset until an event occurs, every strobe output and both verdict counters read 0.
- R2: A sampled rising edge of `req` opens a window with a count of 0. A valid event sampled at that same clock edge is not counted. Events at later edges are counted.
- R3: The first rising edge of `ack` inside an open window closes it. Exactly one of `pass_o` (count ≥ MIN_EVENTS) or `fail_o` (count < MIN_EVENTS) is high for one cycle, in the cycle that follows the clock edge that sampled the rise.
- R4: In rise mode (EDGE_RISE), a `vld` held high for several cycles counts as one event. Events separated by any number of low cycles each count. The window count saturates, so any number of events at or above the minimum still passes.
- R5: In both-edges mode (EDGE_BOTH), each 0-to-1 and each 1-to-0 change of `vld` counts as one event. This includes the fall that follows a rise seen at the opening edge.
- R6: When `ack` rises while `vld` is high, `conflict_o` is high for one cycle. The `vld` level in that cycle does not add to the count.
- R7: A rising `ack` with no window open raises `unexp_ack_o` for one cycle. It produces no verdict and leaves both counters unchanged.
- R8: A rising `req` while a window is open raises `overlap_o` for one cycle and restarts the count from 0.
- R9: Reset discards any open window. A `req` or `vld` that is already high when reset ends is not taken as a rising edge.
- R10: `pass_cnt_o` and `fail_cnt_o` each add one per verdict of their kind, one cycle after the verdict strobe. Each holds at its all-ones value instead of wrapping. The width is STAT_W, which defaults to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| req | input | 1 | Transaction request, rising edge opens a window |
| vld | input | 1 | Interim valid strobe being counted |
| ack | input | 1 | Completion acknowledge, rising edge closes a window |
| pass_o | output | 1 | One-cycle verdict: enough events seen |
| fail_o | output | 1 | One-cycle verdict: too few events seen |
| conflict_o | output | 1 | One-cycle flag: ack rose with vld high |
| unexp_ack_o | output | 1 | One-cycle flag: ack rose with no window open |
| overlap_o | output | 1 | One-cycle flag: req rose inside an open window |
| pass_cnt_o | output | STAT_W | Saturating total of pass verdicts |
| fail_cnt_o | output | STAT_W | Saturating total of fail verdicts |

## Verification
A wrong window count, or a missed restart, shows up only at the closing acknowledge. It flips that transaction's verdict one cycle after the acknowledge is sampled, and it shows up again in a counter one cycle later. The stimulus therefore sweeps the number of events, how long each is held and the gap between them around the threshold, so that an off-by-one error flips some verdict. A stale edge-history register shows up as an extra or a missing event. The bench exposes this with a valid rising at the opening edge, with signals held high across reset, and with the two modes side by side.

// File: rtl/hswm_pkg.sv
package hswm_pkg;

  typedef enum logic [0:0] {
    EDGE_RISE = 1'b0,
    EDGE_BOTH = 1'b1
  } edge_mode_e;

  typedef struct packed {
    logic pass;
    logic fail;
    logic conflict;
    logic unexp_ack;
    logic overlap;
  } hswm_flags_t;

endpackage

// File: rtl/hswm_rst_sync.sv
module hswm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/hswm_edge_detect.sv
module hswm_edge_detect
  import hswm_pkg::*;
#(
  parameter edge_mode_e MODE = EDGE_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic vld,
  input  logic ack,
  output logic req_rise,
  output logic ack_rise,
  output logic vld_evt
);

  logic req_q;
  logic vld_q;
  logic ack_q;
  logic armed_q;
  logic vld_change;

  // History registers: cleared in reset, armed one cycle after release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      vld_q   <= 1'b0;
      ack_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      req_q   <= req;
      vld_q   <= vld;
      ack_q   <= ack;
      armed_q <= 1'b1;
    end
  end

  generate
    if (MODE == EDGE_BOTH) begin : g_both
      assign vld_change = vld ^ vld_q;
    end else begin : g_rise
      assign vld_change = vld & ~vld_q;
    end
  endgenerate

  assign req_rise = armed_q & req & ~req_q;
  assign ack_rise = armed_q & ack & ~ack_q;
  assign vld_evt  = armed_q & vld_change;

  AST_ACK_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rise |=> !ack_rise);  // R3

endmodule

// File: rtl/hswm_window.sv
module hswm_window
  import hswm_pkg::*;
#(
  parameter int MIN_EVENTS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_rise,
  input  logic        ack_rise,
  input  logic        vld_evt,
  input  logic        vld,
  output hswm_flags_t flags
);

  localparam int CNT_W = $clog2(MIN_EVENTS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_EVENTS);

  logic             open_q,  open_nxt;
  logic [CNT_W-1:0] cnt_q,   cnt_nxt;
  logic             cnt_en;
  hswm_flags_t      flags_q, flags_nxt;

  always_comb begin
    open_nxt  = open_q;
    cnt_nxt   = cnt_q;
    flags_nxt = '0;

    if (open_q && ack_rise) begin
      open_nxt       = 1'b0;
      flags_nxt.pass = (cnt_q >= CNT_MAX);
      flags_nxt.fail = (cnt_q <  CNT_MAX);
    end else if (!open_q && ack_rise) begin
      flags_nxt.unexp_ack = 1'b1;
    end

    if (open_q && !ack_rise && vld_evt && (cnt_q != CNT_MAX)) begin
      cnt_nxt = cnt_q + 1'b1;
    end

    if (req_rise) begin
      open_nxt          = 1'b1;
      cnt_nxt           = '0;
      flags_nxt.overlap = open_q && !ack_rise;
    end

    flags_nxt.conflict = ack_rise && vld;
  end

  assign cnt_en = (cnt_nxt != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      flags_q <= '0;
    end else begin
      open_q  <= open_nxt;
      flags_q <= flags_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign flags = flags_q;

  AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags_q.pass && flags_q.fail));  // R3
  AST_VERDICT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.pass || flags_q.fail) |-> $past(ack_rise));  // R3
  AST_UNEXP_NO_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.unexp_ack |-> !(flags_q.pass || flags_q.fail));  // R7
  AST_OVERLAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.overlap |-> (open_q && cnt_q == '0));  // R8
  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);  // R4

endmodule

// File: rtl/hswm_sat_counter.sv
module hswm_sat_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [WIDTH-1:0] value
);

  localparam logic [WIDTH-1:0] TOP = '1;

  logic [WIDTH-1:0] value_q, value_nxt;
  logic             value_en;

  assign value_en  = inc && (value_q != TOP);
  assign value_nxt = value_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
    end else if (value_en) begin
      value_q <= value_nxt;
    end
  end

  assign value = value_q;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (value_q == TOP) |=> (value_q == TOP));  // R10
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (value_q != $past(value_q)) |-> (value_q == $past(value_q) + 1'b1));  // R10

endmodule

// File: rtl/hs_window_monitor.sv
module hs_window_monitor
  import hswm_pkg::*;
#(
  parameter int         MIN_EVENTS = 2,
  parameter edge_mode_e MODE       = EDGE_RISE,
  parameter int         STAT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              vld,
  input  logic              ack,
  output logic              pass_o,
  output logic              fail_o,
  output logic              conflict_o,
  output logic              unexp_ack_o,
  output logic              overlap_o,
  output logic [STAT_W-1:0] pass_cnt_o,
  output logic [STAT_W-1:0] fail_cnt_o
);

  logic        rst_n_int;
  logic        req_rise;
  logic        ack_rise;
  logic        vld_evt;
  hswm_flags_t flags;

  hswm_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  hswm_edge_detect #(.MODE(MODE)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .req      (req),
    .vld      (vld),
    .ack      (ack),
    .req_rise (req_rise),
    .ack_rise (ack_rise),
    .vld_evt  (vld_evt)
  );

  hswm_window #(.MIN_EVENTS(MIN_EVENTS)) u_window (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .req_rise (req_rise),
    .ack_rise (ack_rise),
    .vld_evt  (vld_evt),
    .vld      (vld),
    .flags    (flags)
  );

  hswm_sat_counter #(.WIDTH(STAT_W)) u_pass_cnt (
    .clk   (clk),
    .rst_n (rst_n_int),
    .inc   (flags.pass),
    .value (pass_cnt_o)
  );

  hswm_sat_counter #(.WIDTH(STAT_W)) u_fail_cnt (
    .clk   (clk),
    .rst_n (rst_n_int),
    .inc   (flags.fail),
    .value (fail_cnt_o)
  );

  assign pass_o      = flags.pass;
  assign fail_o      = flags.fail;
  assign conflict_o  = flags.conflict;
  assign unexp_ack_o = flags.unexp_ack;
  assign overlap_o   = flags.overlap;

  AST_PASS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    pass_o |=> !pass_o);  // R3
  AST_CONFLICT_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n_int)
    conflict_o |-> $past(vld));  // R6

endmodule

// File: tb/hs_window_monitor_bench.sv
module hs_window_monitor_bench;
  import hswm_pkg::*;

  localparam int MINE  = 3;
  localparam int SW_A  = 4;
  localparam int SW_B  = 16;
  localparam int MAX_A = (1 << SW_A) - 1;
  localparam int MAX_B = (1 << SW_B) - 1;

  logic clk = 1'b0;
  logic rst_n, req, vld, ack;

  logic            a_pass, a_fail, a_conf, a_unexp, a_ovl;
  logic [SW_A-1:0] a_pcnt, a_fcnt;
  logic            b_pass, b_fail, b_conf, b_unexp, b_ovl;
  logic [SW_B-1:0] b_pcnt, b_fcnt;

  int total = 0;
  int bad   = 0;
  int ea_p = 0, ea_f = 0, eb_p = 0, eb_f = 0;

  always #10 clk = ~clk;

  hs_window_monitor #(.MIN_EVENTS(MINE), .MODE(EDGE_RISE), .STAT_W(SW_A)) u_hs_window_monitor (
    .clk(clk), .rst_n(rst_n), .req(req), .vld(vld), .ack(ack),
    .pass_o(a_pass), .fail_o(a_fail), .conflict_o(a_conf),
    .unexp_ack_o(a_unexp), .overlap_o(a_ovl),
    .pass_cnt_o(a_pcnt), .fail_cnt_o(a_fcnt));

  hs_window_monitor #(.MIN_EVENTS(MINE), .MODE(EDGE_BOTH), .STAT_W(SW_B)) u_hs_window_monitor_both (
    .clk(clk), .rst_n(rst_n), .req(req), .vld(vld), .ack(ack),
    .pass_o(b_pass), .fail_o(b_fail), .conflict_o(b_conf),
    .unexp_ack_o(b_unexp), .overlap_o(b_ovl),
    .pass_cnt_o(b_pcnt), .fail_cnt_o(b_fcnt));

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sat(int v, int mx);
    return (v > mx) ? mx : v;
  endfunction

  // Drive at a falling edge, return at the next falling edge.
  task automatic cyc(bit r, bit v, bit a);
    req = r; vld = v; ack = a;
    @(negedge clk);
  endtask

  task automatic check_counters(string tag);
    check({tag, " R10 pass_cnt A"}, int'(a_pcnt), ea_p);
    check({tag, " R10 fail_cnt A"}, int'(a_fcnt), ea_f);
    check({tag, " R10 pass_cnt B"}, int'(b_pcnt), eb_p);
    check({tag, " R10 fail_cnt B"}, int'(b_fcnt), eb_f);
  endtask

  // Called right after the ack-rise cycle: checks verdicts, then one idle cycle.
  task automatic close_check(string tag, int na, int nb, bit conf);
    bit pa, pb;
    pa = (na >= MINE);
    pb = (nb >= MINE);
    check({tag, " R3 pass A"}, int'(a_pass), int'(pa));
    check({tag, " R3 fail A"}, int'(a_fail), int'(!pa));
    check({tag, " R5 pass B"}, int'(b_pass), int'(pb));
    check({tag, " R5 fail B"}, int'(b_fail), int'(!pb));
    check({tag, " R6 conflict A"}, int'(a_conf), int'(conf));
    check({tag, " R6 conflict B"}, int'(b_conf), int'(conf));
    check({tag, " R7 no unexp"}, int'(a_unexp | b_unexp), 0);
    cyc(0, 0, 0);
    check({tag, " R3 strobe one cycle"}, int'(a_pass | a_fail | b_pass | b_fail), 0);
    if (pa) ea_p = sat(ea_p + 1, MAX_A); else ea_f = sat(ea_f + 1, MAX_A);
    if (pb) eb_p = sat(eb_p + 1, MAX_B); else eb_f = sat(eb_f + 1, MAX_B);
    check_counters(tag);
  endtask

  // n pulses of vld, each held 'hold' cycles then low 'gap' cycles.
  task automatic txn(int n, int hold, int gap, bit conf);
    cyc(1, 0, 0);
    for (int i = 0; i < n; i++) begin
      repeat (hold) cyc(0, 1, 0);
      repeat (gap)  cyc(0, 0, 0);
    end
    cyc(0, conf, 1);
    close_check($sformatf("txn n=%0d h=%0d g=%0d", n, hold, gap), n, 2 * n, conf);
  endtask

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; vld = 1'b0; ack = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 strobes in reset", int'({a_pass, a_fail, a_conf, a_unexp, a_ovl,
                                       b_pass, b_fail, b_conf, b_unexp, b_ovl}), 0);
    check_counters("R1 reset");
    rst_n = 1'b1;
    repeat (3) cyc(0, 0, 0);
    check("R1 strobes after reset", int'({a_pass, a_fail, a_conf, a_unexp, a_ovl,
                                          b_pass, b_fail, b_conf, b_unexp, b_ovl}), 0);

    // R4/R5/R10: sweep event count, hold length and gap around the threshold
    for (int n = 0; n <= 5; n++)
      for (int h = 1; h <= 3; h++)
        for (int g = 1; g <= 2; g++)
          txn(n, h, g, 1'b0);
    check("R10 A pass saturated", int'(a_pcnt), MAX_A);
    check("R10 A fail saturated", int'(a_fcnt), MAX_A);

    // R2: vld rising at the opening edge is not counted
    cyc(1, 1, 0);
    cyc(0, 0, 0);
    for (int i = 0; i < 2; i++) begin
      cyc(0, 1, 0);
      cyc(0, 0, 0);
    end
    cyc(0, 0, 1);
    close_check("R2 open-edge vld", 2, 5, 1'b0);

    // R6: ack rising with vld high, that vld not counted
    txn(2, 1, 1, 1'b1);
    cyc(0, 0, 0);

    // R7: unexpected ack with no window open
    cyc(0, 0, 1);
    check("R7 unexp A", int'(a_unexp), 1);
    check("R7 unexp B", int'(b_unexp), 1);
    check("R7 no verdict", int'(a_pass | a_fail | b_pass | b_fail), 0);
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    check_counters("R7 unchanged");

    // R8: req re-rises inside an open window and restarts the count
    cyc(1, 0, 0);
    for (int i = 0; i < 2; i++) begin
      cyc(0, 1, 0);
      cyc(0, 0, 0);
    end
    cyc(1, 0, 0);
    check("R8 overlap A", int'(a_ovl), 1);
    check("R8 overlap B", int'(b_ovl), 1);
    cyc(0, 0, 0);
    check("R8 overlap one cycle", int'(a_ovl | b_ovl), 0);
    cyc(0, 1, 0);
    cyc(0, 0, 0);
    cyc(0, 0, 1);
    close_check("R8 restart", 1, 2, 1'b0);

    // R9: reset discards the window; high inputs at release are not edges
    cyc(1, 0, 0);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 1, 0);
      cyc(0, 0, 0);
    end
    req = 1'b1; vld = 1'b1; ack = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    ea_p = 0; ea_f = 0; eb_p = 0; eb_f = 0;
    check_counters("R9 in reset");
    rst_n = 1'b1;
    repeat (4) cyc(1, 1, 0);
    cyc(1, 0, 0);
    check("R9 no window after reset", int'(a_unexp | b_unexp | a_ovl | b_ovl), 0);
    cyc(1, 0, 1);
    check("R9 ack unexpected A", int'(a_unexp), 1);
    check("R9 ack unexpected B", int'(b_unexp), 1);
    check("R9 no verdict", int'(a_pass | a_fail | b_pass | b_fail), 0);
    cyc(0, 0, 0);
    txn(3, 2, 1, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule